// File: doc/BRIEF.md
# External Interrupt Request Latch

This block is the recognition stage for one external interrupt line of a small 8-bit processor. The pin is active low and idles high, so an unused pin that is tied to the supply never requests. A chain of synchronizer flops samples the pin. A falling edge on the synchronized line sets a request latch. The latch keeps the request until the CPU sequencer clears it while it fetches the interrupt vector. When the sequencer strobes an instruction boundary, the block signals it to take the interrupt, but only if the latch is set and the global mask bit is clear.

The latch is cleared at vector fetch and not at the end of the service routine. A pulse that arrives while the routine runs is therefore held, and it is taken at the first boundary after the return instruction clears the mask. A pulse that lands in the interrupt entry sequence before the vector fetch merges with the request that is already being serviced. For every pulse to get its own service, consecutive pulses must be spaced by at least 19 instruction cycles plus the length of the service routine, not counting the return instruction.

A mode input adds level sensitivity for sources that are wire-ORed onto the pin. In that mode, a line that is still low after service keeps setting the latch, so it keeps requesting.

Top module: `ext_irq_latch`

## Requirements
- R1: After reset, the synchronizer holds the inactive (high) state and the latch is clear. With the pin high, a boundary strobe with the mask clear gives no take.
- R2: With the default of 2 synchronizer stages, the latch is set by a pin low level that is first sampled at rising edge n. A strobe in the cycle after edge n+2 takes the request. A strobe in any earlier cycle does not.
- R3: `take_irq_o` is high in exactly those cycles in which `insn_bound_i` is 1, `imask_i` is 0 and the latch is set. There are no other cycles in which it is high.
- R4: While `imask_i` is 1, boundary strobes give no take, and the latch keeps its request. A later strobe with the mask clear takes it.
- R5: `vec_fetch_i` high in a cycle with no set request clears the latch at that cycle's edge. A following strobe gives no take.
- R6: A pulse that arrives after the vector fetch but before the return is held. It is taken in the first cycle in which the mask is clear again.
- R7: With `level_en_i` = 0 (edge only), a pin held low after the latch was cleared does not set it again.
- R8: With `level_en_i` = 1 (edge and level), a synchronized low level sets the latch every cycle, and this wins over a vector-fetch clear in the same cycle. Once the synchronized line is high again, a clear holds.
- R9: A falling edge in the same cycle as a vector-fetch clear leaves the latch set.
- R10: Pulses spaced by at least 19 + service-length cycles plus the synchronizer latency each get one take. A pulse that lands in the entry sequence before the vector fetch gets no take of its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_n_i | input | 1 | Interrupt pin, active low, asynchronous |
| level_en_i | input | 1 | 0: edge only; 1: edge and low level |
| insn_bound_i | input | 1 | Instruction-boundary strobe from the sequencer |
| imask_i | input | 1 | Global interrupt mask bit; 1 blocks the take |
| vec_fetch_i | input | 1 | Vector-fetch strobe; clears the latch |
| take_irq_o | output | 1 | Begin the interrupt sequence; high on a qualifying strobe |

## Verification
The latch is only visible through `take_irq_o`. A latch that is stuck or dropped shows up at the next boundary strobe with the mask clear, and that is the same cycle when strobes arrive every cycle. A synchronizer that is too short or too long moves the first take by one cycle from the expected edge count. A lost concurrent set or a wrong level priority shows at the strobe right after the vector fetch. A wrong clear point shows only at the return, as a missing or extra take in the cycle after the mask clears.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic {
    TRIG_EDGE       = 1'b0,
    TRIG_EDGE_LEVEL = 1'b1
  } trig_mode_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] stage_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= 1'b1;
        else         stage_q[g] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= 1'b1;
        else         stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_edge_det.sv
module irq_edge_det
  import irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       line_i,
  input  trig_mode_e mode_i,
  output logic       set_o
);
  logic line_prev_q;
  logic fall;
  logic low_lvl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_prev_q <= 1'b1;
    else         line_prev_q <= line_i;
  end

  assign fall    = line_prev_q & ~line_i;
  assign low_lvl = (mode_i == TRIG_EDGE_LEVEL) & ~line_i;
  assign set_o   = fall | low_lvl;
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic req_o
);
  logic req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     req_q <= 1'b0;
    else if (set_i)  req_q <= 1'b1;
    else if (clr_i)  req_q <= 1'b0;
  end

  assign req_o = req_q;
endmodule

// File: rtl/ext_irq_latch.sv
module ext_irq_latch
  import irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic irq_n_i,
  input  logic level_en_i,
  input  logic insn_bound_i,
  input  logic imask_i,
  input  logic vec_fetch_i,
  output logic take_irq_o
);
  logic       line_sync;
  logic       set_req;
  logic       req_q;
  trig_mode_e mode;

  assign mode = trig_mode_e'(level_en_i);

  irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (irq_n_i),
    .sync_o  (line_sync)
  );

  irq_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (line_sync),
    .mode_i (mode),
    .set_o  (set_req)
  );

  irq_req_latch u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_req),
    .clr_i  (vec_fetch_i),
    .req_o  (req_q)
  );

  assign take_irq_o = req_q & insn_bound_i & ~imask_i;
endmodule

// File: rtl/ext_irq_latch_chk.sv
module ext_irq_latch_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic insn_bound_i,
  input logic imask_i,
  input logic vec_fetch_i,
  input logic take_irq_o,
  input logic set_req,
  input logic req_q
);
  // R3
  take_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_irq_o |-> (insn_bound_i && !imask_i && req_q));

  // R9
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_req |=> req_q);

  // R5
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_fetch_i && !set_req) |=> !req_q);

  // R4
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && !vec_fetch_i) |=> req_q);

  // R1
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_q && !set_req) |=> !req_q);
endmodule

bind ext_irq_latch ext_irq_latch_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .insn_bound_i (insn_bound_i),
  .imask_i      (imask_i),
  .vec_fetch_i  (vec_fetch_i),
  .take_irq_o   (take_irq_o),
  .set_req      (set_req),
  .req_q        (req_q)
);

// File: tb/ext_irq_latch_tb_top.sv
module ext_irq_latch_tb_top;
  localparam int SEQ_CYC = 19;
  localparam int VF_AT   = 10;
  localparam int SVC_CYC = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 1'b1, lvl = 1'b0, bnd = 1'b0, msk = 1'b0, vf = 1'b0;
  logic take;

  int n_chk = 0, n_bad = 0;
  bit last_take;
  bit done = 1'b0;
  // bench reference state, built from R1/R2/R5/R8/R9
  bit ms1, ms2, mprev, mlat;

  always #2 clk = ~clk;

  ext_irq_latch dut_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_n_i(pin), .level_en_i(lvl),
    .insn_bound_i(bnd), .imask_i(msk), .vec_fetch_i(vf), .take_irq_o(take)
  );

  function automatic bit exp_take(bit b, bit m, bit l);
    return b & ~m & l;
  endfunction

  function automatic bit next_lat(bit prev, bit s2, bit lv, bit clr, bit l);
    if ((prev & ~s2) | (lv & ~s2)) return 1'b1;
    if (clr) return 1'b0;
    return l;
  endfunction

  task automatic check(string req, bit act, bit exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: take_irq_o=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: inputs already set after negedge
  task automatic tick(string req = "", bit chk = 1'b0, bit expv = 1'b0);
    #1;
    last_take = take;
    if (rst_n) begin
      check("R3 model", take, exp_take(bnd, msk, mlat));
      if (chk) check(req, take, expv);
    end
    if (!rst_n) begin
      ms1 = 1; ms2 = 1; mprev = 1; mlat = 0;
    end else begin
      mlat  = next_lat(mprev, ms2, lvl, vf, mlat);
      mprev = ms2; ms2 = ms1; ms1 = pin;
    end
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      bnd = 0; vf = 0; tick();
    end
  endtask

  // CPU model: strobe every cycle, entry sequence, service, return
  task automatic cpu_run(int p0, int p1, int p2, int ncyc, bit hold_low,
                         output int takes, output int t1, output int rti1);
    int seq = -1;
    takes = 0; t1 = -1; rti1 = -1;
    for (int c = 0; c < ncyc; c++) begin
      pin = hold_low ? 1'b0 :
            !((c >= p0 && c < p0+3) || (c >= p1 && c < p1+3) || (c >= p2 && c < p2+3));
      if (seq < 0) begin bnd = 1; msk = 0; vf = 0; end
      else if (seq < SEQ_CYC) begin bnd = 0; msk = 1; vf = (seq == VF_AT); end
      else begin bnd = 1; msk = 1; vf = 0; end
      tick();
      if (seq >= 0) begin
        seq++;
        if (seq == SEQ_CYC + SVC_CYC) begin
          seq = -1;
          if (rti1 < 0) rti1 = c + 1;
        end
      end else if (last_take) begin
        takes++;
        if (takes == 2) t1 = c;
        seq = 0;
      end
    end
    pin = 1; bnd = 0; msk = 0; vf = 0;
  endtask

  initial begin : watchdog
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int tk, t1, r1;
    @(negedge clk);
    tick(); tick(); tick();
    rst_n = 1;
    // R1: reset state, pin high
    bnd = 1; tick("R1", 1, 0); tick("R1", 1, 0); bnd = 0; idle(2);

    // R2 latency, R5 clear, R7 edge-only hold-low
    pin = 0; bnd = 1;
    tick("R2", 1, 0); tick("R2", 1, 0); tick("R2", 1, 0); tick("R2", 1, 1);
    bnd = 0; vf = 1; tick(); vf = 0;
    bnd = 1; tick("R5", 1, 0); tick("R7", 1, 0); tick("R7", 1, 0);
    pin = 1; bnd = 0; idle(4);

    // R4 mask blocks and latch holds; R3 no take without strobe
    pin = 0; idle(3); pin = 1;
    bnd = 1; msk = 1; tick("R4", 1, 0);
    bnd = 0; msk = 0; tick("R3", 1, 0);
    bnd = 1; msk = 0; tick("R4", 1, 1);
    bnd = 0; idle(3);

    // R9 edge concurrent with clear (latch still set)
    pin = 0; idle(2); vf = 1; tick(); vf = 0;
    pin = 1; bnd = 1; tick("R9", 1, 1);
    bnd = 0; vf = 1; tick(); vf = 0;
    bnd = 1; tick("R5", 1, 0); bnd = 0; idle(3);

    // R8 level mode
    lvl = 1; pin = 0; idle(3);
    bnd = 1; tick("R8", 1, 1); bnd = 0;
    vf = 1; tick(); vf = 0;
    bnd = 1; tick("R8", 1, 1); bnd = 0;
    pin = 1; idle(2);
    vf = 1; tick(); vf = 0;
    bnd = 1; tick("R8", 1, 0); bnd = 0;
    lvl = 0; idle(3);

    // R10 spacing rule under CPU model
    cpu_run(2, 2 + SEQ_CYC + SVC_CYC + 9, 10000, 90, 0, tk, t1, r1);
    n_chk++; if (tk != 2) begin n_bad++; $display("FAIL R10: takes=%0d expected 2", tk); end
    n_chk++; if (t1 != 2 + SEQ_CYC + SVC_CYC + 12) begin
      n_bad++; $display("FAIL R10: second take cycle=%0d expected %0d", t1, 2+SEQ_CYC+SVC_CYC+12); end
    idle(4);
    // R6 pulse during service, taken at return
    cpu_run(2, 17, 10000, 90, 0, tk, t1, r1);
    n_chk++; if (tk != 2) begin n_bad++; $display("FAIL R6: takes=%0d expected 2", tk); end
    n_chk++; if (t1 != r1) begin n_bad++; $display("FAIL R6: take cycle=%0d expected %0d", t1, r1); end
    idle(4);
    // R6 two pulses in service coalesce
    cpu_run(2, 17, 27, 90, 0, tk, t1, r1);
    n_chk++; if (tk != 2) begin n_bad++; $display("FAIL R6: takes=%0d expected 2", tk); end
    idle(4);
    // R10 pulse inside entry sequence before vector fetch merges
    cpu_run(2, 10, 10000, 90, 0, tk, t1, r1);
    n_chk++; if (tk != 1) begin n_bad++; $display("FAIL R10: takes=%0d expected 1", tk); end
    idle(4);
    // R8 wire-OR line stuck low keeps requesting
    lvl = 1;
    cpu_run(10000, 10000, 10000, 120, 1, tk, t1, r1);
    n_chk++; if (tk < 3) begin n_bad++; $display("FAIL R8: takes=%0d expected >=3", tk); end
    lvl = 0; pin = 1; idle(4);
    bnd = 1; msk = 0; tick("R8", 1, 1); vf = 1; bnd = 0; tick(); vf = 0; idle(3);

    // random mix, checked against bench reference each cycle (R3)
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(7) == 0) pin = ~pin;
      if ($urandom_range(199) == 0) lvl = ~lvl;
      bnd = $urandom_range(2) == 0;
      msk = $urandom_range(3) == 0;
      vf  = $urandom_range(5) == 0;
      tick();
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule